// File: doc/BRIEF.md
# Supervisory Watchdog Timer with Failsafe Boot Select

This block is a watchdog peripheral for a board management controller. Software reaches it over a small byte-wide register port with an address, a write strobe, write data and combinational read data. Three registers are visible: a control byte, a reload period counted in whole seconds, and a kick port that accepts only one magic byte. A divider on the system clock makes the one-second tick. When the countdown runs out while armed, the block pulses a board reset request and, if enabled, a separate timeout indication line. If the recovery enable was the one armed, it also latches a failsafe-boot select.

There are two arm bits. One gives a normal expiry. The other gives a recovery expiry, which steers the next boot into the failsafe image. A strap input decides whether the timer leaves reset already armed, so it can supervise the bootloader until software stops it. A sticky lock bit freezes the control byte until the next block reset. The usual software sequence is: disarm, write the period, kick, arm. If the period is zero, this sequence forces an expiry straight away.

Top module: `sup_wdog`

## Requirements
- R1: In reset, control bit 6 (reset output enable) is set, bits 7 and 2 are clear, bits 1:0 take `strap_en`, the period register and the countdown take `DEF_TIMEOUT`, and all three outputs are low; with a nonzero strap the countdown runs from the first clock after reset.
- R2: Reads are combinational: offset 0 returns control with bits 5:3 reading 0, offset 1 returns the period, and offset 2 and offset 3 return 0.
- R3: Control bit 2 (lock) is sticky: once written as 1, it stays set until a block reset.
- R4: While the lock bit is set, writes to control leave bits 7, 6, 2, 1 and 0 unchanged.
- R5: The period register at offset 1 can be written at any time, and one second is `CLK_PER_SEC` clock cycles.
- R6: Writing 0x6b to offset 2 loads the countdown from the period register and restarts the second divider. When the timer is armed, outputs rise exactly period*`CLK_PER_SEC`+1 clock edges after the later of the kick and the arming write.
- R7: A write to offset 2 of any byte other than 0x6b has no effect on the countdown or on the expiry time.
- R8: With a period of 0, a kick followed by an arming write makes the outputs rise on the very next clock edge.
- R9: On expiry, `board_rst_req` pulses high for `PULSE_CYCLES` cycles only if control bit 6 was set, and `tmo_line` pulses for the same cycles only if control bit 7 was set.
- R10: `failsafe_sel` goes high at an expiry during which control bit 1 (recovery arm) was set, and it stays high until reset. An expiry armed only by bit 0 leaves it low.
- R11: An expiry clears control bits 1:0, and no further expiry occurs until software re-arms the timer.
- R12: Clearing both arm bits before the countdown ends stops the timer, and no expiry follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| strap_en | input | 2 | Reset value of the arm bits (bit 0 normal, bit 1 recovery) |
| bus_addr | input | ADDR_W | Register offset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` |
| board_rst_req | output | 1 | Board reset request pulse on expiry |
| tmo_line | output | 1 | Timeout indication pulse on expiry |
| failsafe_sel | output | 1 | Latched select for a failsafe boot |

## Verification
The hardest case to reach is an expiry that lands on an exact clock edge, with the second divider and the countdown each in a known phase. The kick restarts the divider, and the arming write opens it. The stimulus therefore always writes the period, kicks and arms from a known clock edge. Random non-magic kick bytes are dropped into the middle of a countdown. The bench then samples one edge before and one edge after the predicted expiry. The zero-period case, a kick in mid-count, and expiry straight out of a strapped reset are driven as directed cases.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int unsigned OFS_CTRL   = 0;
    localparam int unsigned OFS_PERIOD = 1;
    localparam int unsigned OFS_KICK   = 2;
    localparam logic [7:0]  KICK_MAGIC = 8'h6b;

    typedef struct packed {
        logic tmo_en;   // byte bit 7
        logic rst_en;   // byte bit 6
        logic lock;     // byte bit 2
        logic rcv_en;   // byte bit 1
        logic nrm_en;   // byte bit 0
    } ctrl_t;

    function automatic logic [7:0] ctrl_to_byte(ctrl_t c);
        return {c.tmo_en, c.rst_en, 3'b000, c.lock, c.rcv_en, c.nrm_en};
    endfunction

    function automatic ctrl_t byte_to_ctrl(logic [7:0] b);
        ctrl_t c;
        c.tmo_en = b[7];
        c.rst_en = b[6];
        c.lock   = b[2];
        c.rcv_en = b[1];
        c.nrm_en = b[0];
        return c;
    endfunction

endpackage

// File: rtl/wdog_tick.sv
module wdog_tick #(
    parameter int unsigned CLK_PER_SEC = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int unsigned PW = (CLK_PER_SEC > 2) ? $clog2(CLK_PER_SEC) : 1;
    localparam logic [PW-1:0] LAST = PW'(CLK_PER_SEC - 1);

    logic [PW-1:0] pre_d, pre_q;

    always_comb begin
        pre_d = pre_q;
        if (restart || !run)   pre_d = '0;
        else if (pre_q == LAST) pre_d = '0;
        else                   pre_d = pre_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    assign tick = run && (pre_q == LAST);
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int unsigned ADDR_W      = 2,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned DEF_TIMEOUT = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        strap_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              fire,
    output ctrl_t             ctrl,
    output logic [DATA_W-1:0] period,
    output logic              kick,
    output logic [DATA_W-1:0] bus_rdata
);
    typedef struct packed {
        ctrl_t             ctrl;
        logic [DATA_W-1:0] period;
    } regs_t;

    regs_t st_d, st_q;
    logic  sel_ctrl, sel_period, sel_kick;

    assign sel_ctrl   = (bus_addr == ADDR_W'(OFS_CTRL));
    assign sel_period = (bus_addr == ADDR_W'(OFS_PERIOD));
    assign sel_kick   = (bus_addr == ADDR_W'(OFS_KICK));

    always_comb begin
        st_d = st_q;
        if (bus_we && sel_ctrl && !st_q.ctrl.lock)
            st_d.ctrl = byte_to_ctrl(bus_wdata[7:0]);
        if (bus_we && sel_period)
            st_d.period = bus_wdata;
        if (fire) begin
            st_d.ctrl.nrm_en = 1'b0;
            st_d.ctrl.rcv_en = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ctrl.tmo_en <= 1'b0;
            st_q.ctrl.rst_en <= 1'b1;
            st_q.ctrl.lock   <= 1'b0;
            st_q.ctrl.rcv_en <= strap_en[1];
            st_q.ctrl.nrm_en <= strap_en[0];
            st_q.period      <= DATA_W'(DEF_TIMEOUT);
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl   = st_q.ctrl;
    assign period = st_q.period;
    assign kick   = bus_we && sel_kick && (bus_wdata == DATA_W'(KICK_MAGIC));

    always_comb begin
        if (sel_ctrl)        bus_rdata = DATA_W'(ctrl_to_byte(st_q.ctrl));
        else if (sel_period) bus_rdata = st_q.period;
        else                 bus_rdata = '0;
    end
endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown #(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned DEF_TIMEOUT = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kick,
    input  logic [DATA_W-1:0] reload,
    input  logic              tick,
    output logic [DATA_W-1:0] cnt
);
    logic [DATA_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (kick)                    cnt_d = reload;
        else if (tick && cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= DATA_W'(DEF_TIMEOUT);
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
    parameter int unsigned PULSE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic rst_en,
    input  logic tmo_en,
    input  logic rcv_en,
    output logic board_rst_req,
    output logic tmo_line,
    output logic failsafe_sel
);
    localparam int unsigned PW = $clog2(PULSE_CYCLES + 1);

    typedef struct packed {
        logic [PW-1:0] left;
        logic          rst_sel;
        logic          tmo_sel;
        logic          fsafe;
    } pulse_t;

    pulse_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.left != '0) st_d.left = st_q.left - 1'b1;
        if (fire) begin
            st_d.left    = PW'(PULSE_CYCLES);
            st_d.rst_sel = rst_en;
            st_d.tmo_sel = tmo_en;
            if (rcv_en) st_d.fsafe = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign board_rst_req = (st_q.left != '0) && st_q.rst_sel;
    assign tmo_line      = (st_q.left != '0) && st_q.tmo_sel;
    assign failsafe_sel  = st_q.fsafe;
endmodule

// File: rtl/sup_wdog.sv
module sup_wdog
    import wdog_pkg::*;
#(
    parameter int unsigned ADDR_W       = 2,
    parameter int unsigned DATA_W       = 8,
    parameter int unsigned CLK_PER_SEC  = 50_000_000,
    parameter int unsigned PULSE_CYCLES = 16,
    parameter int unsigned DEF_TIMEOUT  = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        strap_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              board_rst_req,
    output logic              tmo_line,
    output logic              failsafe_sel
);
    ctrl_t             ctrl_w;
    logic [DATA_W-1:0] period_w;
    logic [DATA_W-1:0] cnt_w;
    logic              kick_w, tick_w, armed_w, fire_w;

    assign armed_w = ctrl_w.nrm_en || ctrl_w.rcv_en;
    assign fire_w  = armed_w && (cnt_w == '0);

    wdog_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEF_TIMEOUT(DEF_TIMEOUT)) u_regs (
        .clk(clk), .rst_n(rst_n), .strap_en(strap_en),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .fire(fire_w), .ctrl(ctrl_w), .period(period_w), .kick(kick_w),
        .bus_rdata(bus_rdata)
    );

    wdog_tick #(.CLK_PER_SEC(CLK_PER_SEC)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(armed_w), .restart(kick_w), .tick(tick_w)
    );

    wdog_countdown #(.DATA_W(DATA_W), .DEF_TIMEOUT(DEF_TIMEOUT)) u_cnt (
        .clk(clk), .rst_n(rst_n), .kick(kick_w), .reload(period_w),
        .tick(tick_w), .cnt(cnt_w)
    );

    wdog_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
        .clk(clk), .rst_n(rst_n), .fire(fire_w),
        .rst_en(ctrl_w.rst_en), .tmo_en(ctrl_w.tmo_en), .rcv_en(ctrl_w.rcv_en),
        .board_rst_req(board_rst_req), .tmo_line(tmo_line), .failsafe_sel(failsafe_sel)
    );
endmodule

// File: rtl/sup_wdog_chk.sv
module sup_wdog_chk
    import wdog_pkg::*;
#(
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input ctrl_t             ctrl,
    input logic [DATA_W-1:0] period,
    input logic [DATA_W-1:0] cnt,
    input logic              board_rst_req,
    input logic              failsafe_sel
);
    logic magic;
    assign magic = bus_we && (bus_addr == ADDR_W'(OFS_KICK)) && (bus_wdata == DATA_W'(KICK_MAGIC));

    a_r3_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.lock |=> ctrl.lock);

    a_r4_locked_outputs_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.lock |=> $stable({ctrl.tmo_en, ctrl.rst_en}));

    a_r6_kick_loads_period: assert property (@(posedge clk) disable iff (!rst_n)
        magic |=> (cnt == $past(period)));

    a_r7_no_reload_without_magic: assert property (@(posedge clk) disable iff (!rst_n)
        !magic |=> (cnt <= $past(cnt)));

    a_r9_reset_pulse_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(board_rst_req) |-> $past(ctrl.rst_en));

    a_r10_failsafe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        failsafe_sel |=> failsafe_sel);

    a_r11_disarmed_after_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(board_rst_req) |-> (!ctrl.nrm_en && !ctrl.rcv_en));
endmodule

bind sup_wdog sup_wdog_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .ctrl(ctrl_w), .period(period_w), .cnt(cnt_w),
    .board_rst_req(board_rst_req), .failsafe_sel(failsafe_sel)
);

// File: tb/sup_wdog_bench.sv
module sup_wdog_bench;
    localparam int D    = 8;
    localparam int P    = 3;
    localparam int DEFT = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] strap_en = 2'b00;
    logic [1:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       board_rst_req, tmo_line, failsafe_sel;

    int errors = 0;
    int checks = 0;
    int rises  = 0;
    logic prev_rst = 1'b0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    sup_wdog #(.ADDR_W(2), .DATA_W(8), .CLK_PER_SEC(D), .PULSE_CYCLES(P), .DEF_TIMEOUT(DEFT)) u_sup_wdog (
        .clk(clk), .rst_n(rst_n), .strap_en(strap_en), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .board_rst_req(board_rst_req), .tmo_line(tmo_line), .failsafe_sel(failsafe_sel)
    );

    always @(negedge clk) begin
        if (board_rst_req && !prev_rst) rises++;
        prev_rst = board_rst_req;
    end

    function automatic logic [7:0] ctrl_byte(logic tmo, logic rst, logic lk, logic [1:0] en);
        return {tmo, rst, 3'b000, lk, en};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, logic [7:0] exp, string req);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic do_reset(logic [1:0] strap);
        rst_n = 1'b0; strap_en = strap;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic expect_expiry(int t, logic e_rst, logic e_tmo, logic e_fs, string req);
        repeat (t * D) @(negedge clk);
        check({req, " before edge"}, {board_rst_req, tmo_line}, 2'b00);
        @(negedge clk);
        check({req, " pulse start"}, {board_rst_req, tmo_line, failsafe_sel}, {e_rst, e_tmo, e_fs});
        repeat (P - 1) @(negedge clk);
        check({req, " pulse last"}, {board_rst_req, tmo_line}, {e_rst, e_tmo});
        @(negedge clk);
        check({req, " pulse end"}, {board_rst_req, tmo_line}, 2'b00);
    endtask

    initial begin
        int r0;
        void'($urandom(32'd1357));
        @(negedge clk);
        // R1 / R2 reset state and map
        do_reset(2'b00);
        rd(2'd0, 8'h40, "R1 ctrl reset");
        rd(2'd1, 8'(DEFT), "R1 period reset");
        rd(2'd2, 8'h00, "R2 kick reads zero");
        rd(2'd3, 8'h00, "R2 unused offset");
        check("R1 outputs low", {board_rst_req, tmo_line, failsafe_sel}, 3'b000);
        wr(2'd1, 8'h5a);
        rd(2'd1, 8'h5a, "R5 period write");
        wr(2'd0, 8'h38);
        rd(2'd0, 8'h00, "R2 ctrl unused bits");

        // R12 disarm stops the timer
        r0 = rises;
        wr(2'd1, 8'd2); wr(2'd2, 8'h6b); wr(2'd0, 8'h41);
        repeat (5) @(negedge clk);
        wr(2'd0, 8'h40);
        repeat (4 * D) @(negedge clk);
        check("R12 no expiry after disarm", rises, r0);

        // R6 normal expiry with both outputs, R11 afterwards
        wr(2'd1, 8'd2); wr(2'd2, 8'h6b); wr(2'd0, 8'hC1);
        expect_expiry(2, 1'b1, 1'b1, 1'b0, "R6 R9 normal expiry");
        rd(2'd0, 8'hC0, "R11 arm bits cleared");
        r0 = rises;
        repeat (4 * D) @(negedge clk);
        check("R11 no second expiry", rises, r0);

        // R6 kick in mid-count restarts the window
        do_reset(2'b00);
        wr(2'd1, 8'd3); wr(2'd2, 8'h6b); wr(2'd0, 8'h41);
        repeat (D + 3) @(negedge clk);
        wr(2'd2, 8'h6b);
        expect_expiry(3, 1'b1, 1'b0, 1'b0, "R6 mid kick");

        // R8 zero period immediate, R10 recovery select
        do_reset(2'b00);
        wr(2'd1, 8'd0); wr(2'd2, 8'h6b); wr(2'd0, 8'h42);
        expect_expiry(0, 1'b1, 1'b0, 1'b1, "R8 R10 immediate recovery");
        repeat (2 * D) @(negedge clk);
        check("R10 failsafe held", failsafe_sel, 1'b1);

        // R9 timeout line only
        do_reset(2'b00);
        check("R10 failsafe cleared by reset", failsafe_sel, 1'b0);
        wr(2'd1, 8'd1); wr(2'd2, 8'h6b); wr(2'd0, 8'h81);
        expect_expiry(1, 1'b0, 1'b1, 1'b0, "R9 timeout line only");

        // R3 / R4 lock
        do_reset(2'b00);
        wr(2'd0, 8'h44);
        wr(2'd0, 8'hC3);
        rd(2'd0, 8'h44, "R4 locked write ignored");
        wr(2'd0, 8'h00);
        rd(2'd0, 8'h44, "R3 lock cannot be cleared");
        do_reset(2'b00);
        rd(2'd0, 8'h40, "R3 reset clears lock");

        // R1 strapped start
        do_reset(2'b01);
        rd(2'd0, 8'h41, "R1 strap arms");
        expect_expiry(DEFT, 1'b1, 1'b0, 1'b0, "R1 strapped expiry");

        // random mix, R7 bad kicks
        for (int i = 0; i < 8; i++) begin
            int t, split;
            logic [1:0] en, oe;
            logic [7:0] bad;
            logic use_bad;
            t = $urandom_range(1, 4);
            en = 2'($urandom_range(1, 3));
            oe = 2'($urandom_range(0, 3));
            use_bad = 1'($urandom_range(0, 1));
            bad = 8'($urandom_range(0, 255));
            if (bad == 8'h6b) bad = 8'h6a;
            do_reset(2'b00);
            wr(2'd1, 8'(t)); wr(2'd2, 8'h6b);
            wr(2'd0, ctrl_byte(oe[1], oe[0], 1'b0, en));
            if (use_bad) begin
                split = $urandom_range(0, t * D - 2);
                repeat (split) @(negedge clk);
                wr(2'd2, bad);
                repeat (t * D - split - 1) @(negedge clk);
            end else begin
                repeat (t * D) @(negedge clk);
            end
            check("R7 random before edge", {board_rst_req, tmo_line}, 2'b00);
            @(negedge clk);
            check("R7 R9 R10 random expiry", {board_rst_req, tmo_line, failsafe_sel}, {oe[0], oe[1], en[1]});
            rd(2'd0, ctrl_byte(oe[1], oe[0], 1'b0, 2'b00), "R11 random disarm");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule